// File: doc/BRIEF.md
# Time-Slotted Banked Vector Register File

This block holds 128 vector registers of 64 bits each in one wide single-port memory. The memory is built from two half-width banks that are always addressed together, so each access moves a whole group of four registers (256 bits). Register number `r` belongs to group `r >> 2` and sits in lane `r % 4` of that group.

Access to the memory follows a fixed four-clock round driven by a 2-bit slot counter. Slot 0 reads the first source group, slot 1 the second, and slot 2 the third. Slot 3 writes one result group. The execution pipeline issues one instruction per round. Three flip-flop collectors hold the read groups and present all three operands together in one cycle. When the instruction in a round has no third operand, or no instruction is active, slot 2 serves the head of a small load/store request queue. A load writes its group in that slot and a store reads its group. Results that arrive outside slot 3 wait in a one-entry staging register until the next slot 3.

Top module: `slotted_vrf`

## Requirements
- R1: On synchronous reset the slot counter is 0 and `op_valid` and `st_valid` are low. `iss_ready` is low in the first cycle after reset and `mreq_ready` is high.
- R2: The slot counter steps 0,1,2,3 and wraps. `iss_ready` can be high only in slot 3, and it is high there unless R8 applies, so at most one instruction is accepted per four clocks.
- R3: Group G holds registers 4G to 4G+3. Register 4G+i occupies bits [64i+63:64i] of every 256-bit data port. Data written to a group is read back bit for bit.
- R4: An instruction accepted in slot 3 has its groups read in the next slots 0, 1 and 2. `op_valid` is then high for exactly the one slot-0 cycle that follows, with `op_a`, `op_b` and `op_c` holding the first, second and third source groups.
- R5: When `iss_use3` was low for the instruction, `op_c` is all zeros while `op_valid` is high.
- R6: A result arriving in slot 3 with the staging register empty is written in that same cycle. A result arriving in any other slot is staged and written in the next slot 3.
- R7: A group written in slot 3 returns the new data to a read of that group in the following slot 0.
- R8: In slot 3, if the staging register is full and another result arrives in the same cycle, `iss_ready` is low. The staged result is written and the new one is staged.
- R9: A queued request is served only in slot 2, and only when the active instruction does not use a third operand. Requests are served in arrival order. A waiting request is kept until it is served.
- R10: A store served in slot 2 drives `st_valid` high for the following slot-0 cycle, with `st_data` holding the group contents.
- R11: A load served in slot 2 writes its data to its group, and later reads of that group return it.
- R12: The request queue holds 2 entries. `mreq_ready` is low exactly when it is full, and a request is accepted when `mreq_valid` and `mreq_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Instruction accepted this cycle if valid |
| iss_src1_grp | input | 5 | First source group |
| iss_src2_grp | input | 5 | Second source group |
| iss_src3_grp | input | 5 | Third source group |
| iss_use3 | input | 1 | Instruction needs a third operand |
| res_valid | input | 1 | Result group arriving |
| res_grp | input | 5 | Destination group of the result |
| res_data | input | 256 | Four result lanes |
| mreq_valid | input | 1 | Memory request offered |
| mreq_ready | output | 1 | Request queue has room |
| mreq_load | input | 1 | 1 = load (write group), 0 = store (read group) |
| mreq_grp | input | 5 | Group of the request |
| mreq_data | input | 256 | Load data |
| op_valid | output | 1 | Operand groups valid |
| op_a | output | 256 | First source group |
| op_b | output | 256 | Second source group |
| op_c | output | 256 | Third source group or zero |
| st_valid | output | 1 | Store read data valid |
| st_data | output | 256 | Store read data |

## Verification
The hardest state to reach is a queued load held back across several rounds. That needs the queue full while back-to-back three-operand instructions take every slot 2, and then draining in order once the slot frees up. A directed sequence issues such instructions and pushes loads until `mreq_ready` drops. It then stops issuing and reads the loaded groups back through the operand ports. A second hard state is a result collision with a full staging register in slot 3. The bench creates it by landing one result in slot 0 and a second in the next slot 3, with an instruction offered in that cycle. Random rounds mixing instructions, results and requests are checked against a cycle model of the slot schedule.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int SLOTS = 4;

  typedef enum logic [1:0] {
    SL_SRC1  = 2'd0,
    SL_SRC2  = 2'd1,
    SL_SRC3  = 2'd2,
    SL_WRITE = 2'd3
  } slot_e;
endpackage

// File: rtl/vrf_slot_seq.sv
module vrf_slot_seq
  import vrf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e slot
);
  always_ff @(posedge clk) begin
    if (rst) slot <= SL_SRC1;
    else     slot <= slot_e'(2'(slot) + 2'd1);
  end
endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/vrf_req_fifo.sv
module vrf_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         pop
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, take;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign take      = pop && out_valid;
  assign out_data  = store[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (take) rd_ptr <= nxt(rd_ptr);
      case ({push, take})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/vrf_collector.sv
module vrf_collector
  import vrf_pkg::*;
#(
  parameter int W        = 256,
  parameter int CAP_SLOT = 1
) (
  input  logic         clk,
  input  slot_e        slot,
  input  logic         keep,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] held
);
  always_ff @(posedge clk) begin
    if (slot == slot_e'(CAP_SLOT)) held <= keep ? rdata : '0;
  end
endmodule

// File: rtl/slotted_vrf.sv
module slotted_vrf
  import vrf_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int NUM_REGS = 128,
  parameter int LANES    = 4,
  parameter int BANKS    = 2,
  parameter int MQ_DEPTH = 2
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     iss_valid,
  output logic                                     iss_ready,
  input  logic [$clog2(NUM_REGS/LANES)-1:0]        iss_src1_grp,
  input  logic [$clog2(NUM_REGS/LANES)-1:0]        iss_src2_grp,
  input  logic [$clog2(NUM_REGS/LANES)-1:0]        iss_src3_grp,
  input  logic                                     iss_use3,
  input  logic                                     res_valid,
  input  logic [$clog2(NUM_REGS/LANES)-1:0]        res_grp,
  input  logic [REG_W*LANES-1:0]                   res_data,
  input  logic                                     mreq_valid,
  output logic                                     mreq_ready,
  input  logic                                     mreq_load,
  input  logic [$clog2(NUM_REGS/LANES)-1:0]        mreq_grp,
  input  logic [REG_W*LANES-1:0]                   mreq_data,
  output logic                                     op_valid,
  output logic [REG_W*LANES-1:0]                   op_a,
  output logic [REG_W*LANES-1:0]                   op_b,
  output logic [REG_W*LANES-1:0]                   op_c,
  output logic                                     st_valid,
  output logic [REG_W*LANES-1:0]                   st_data
);
  localparam int GROUPS = NUM_REGS / LANES;
  localparam int GA     = $clog2(GROUPS);
  localparam int ROW_W  = REG_W * LANES;
  localparam int BANK_W = ROW_W / BANKS;
  localparam int MQ_W   = 1 + GA + ROW_W;
  localparam int NCOL   = SLOTS - 1;

  slot_e slot;
  vrf_slot_seq u_seq (.clk(clk), .rst(rst), .slot(slot));

  // active instruction of the current round
  logic          act_valid, act_use3;
  logic [GA-1:0] act_g1, act_g2, act_g3;
  logic          accept;

  // staging register for results
  logic             stg_full;
  logic [GA-1:0]    stg_grp;
  logic [ROW_W-1:0] stg_data;

  // request queue head
  logic             mq_valid, mq_load;
  logic [GA-1:0]    mq_grp;
  logic [ROW_W-1:0] mq_data;
  logic [MQ_W-1:0]  mq_head;

  // memory port
  logic             mem_we, mem_grant;
  logic [GA-1:0]    mem_addr;
  logic [ROW_W-1:0] mem_wdata, mem_rdata;
  logic             st_pend;

  assign iss_ready = (slot == SL_WRITE) && !(stg_full && res_valid);
  assign accept    = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_use3  <= 1'b0;
    end else if (slot == SL_WRITE) begin
      act_valid <= accept;
      act_use3  <= accept && iss_use3;
    end
  end

  always_ff @(posedge clk) begin
    if (slot == SL_WRITE && accept) begin
      act_g1 <= iss_src1_grp;
      act_g2 <= iss_src2_grp;
      act_g3 <= iss_src3_grp;
    end
  end

  vrf_req_fifo #(.W(MQ_W), .DEPTH(MQ_DEPTH)) u_mq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (mreq_valid),
    .in_ready (mreq_ready),
    .in_data  ({mreq_load, mreq_grp, mreq_data}),
    .out_valid(mq_valid),
    .out_data (mq_head),
    .pop      (mem_grant)
  );
  assign {mq_load, mq_grp, mq_data} = mq_head;

  // slot arbiter for the single memory port
  always_comb begin
    mem_we    = 1'b0;
    mem_grant = 1'b0;
    mem_addr  = act_g1;
    mem_wdata = stg_data;
    case (slot)
      SL_SRC1: mem_addr = act_g1;
      SL_SRC2: mem_addr = act_g2;
      SL_SRC3: begin
        if (act_valid && act_use3) begin
          mem_addr = act_g3;
        end else if (mq_valid) begin
          mem_grant = 1'b1;
          mem_addr  = mq_grp;
          mem_we    = mq_load;
          mem_wdata = mq_data;
        end
      end
      SL_WRITE: begin
        if (stg_full) begin
          mem_we    = 1'b1;
          mem_addr  = stg_grp;
          mem_wdata = stg_data;
        end else if (res_valid) begin
          mem_we    = 1'b1;
          mem_addr  = res_grp;
          mem_wdata = res_data;
        end
      end
      default: ;
    endcase
  end

  // paired banks, addressed together
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    vrf_bank #(.WIDTH(BANK_W), .DEPTH(GROUPS)) u_bank (
      .clk  (clk),
      .we   (mem_we),
      .addr (mem_addr),
      .wdata(mem_wdata[b*BANK_W +: BANK_W]),
      .rdata(mem_rdata[b*BANK_W +: BANK_W])
    );
  end

  // result staging
  always_ff @(posedge clk) begin
    if (rst)                     stg_full <= 1'b0;
    else if (slot == SL_WRITE)   stg_full <= stg_full && res_valid;
    else if (res_valid)          stg_full <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (res_valid && (slot != SL_WRITE || stg_full)) begin
      stg_grp  <= res_grp;
      stg_data <= res_data;
    end
  end

  // operand collectors: read in slot k returns in slot k+1
  logic [ROW_W-1:0] col   [NCOL];
  logic [NCOL-1:0]  col_keep;

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    if (i == NCOL - 1) begin : g_opt
      assign col_keep[i] = act_valid && act_use3;
    end else begin : g_req
      assign col_keep[i] = 1'b1;
    end
    vrf_collector #(.W(ROW_W), .CAP_SLOT((i + 1) % SLOTS)) u_col (
      .clk  (clk),
      .slot (slot),
      .keep (col_keep[i]),
      .rdata(mem_rdata),
      .held (col[i])
    );
  end

  assign op_a = col[0];
  assign op_b = col[1];
  assign op_c = col[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      st_valid <= 1'b0;
      st_pend  <= 1'b0;
    end else begin
      op_valid <= (slot == SL_WRITE) && act_valid;
      st_valid <= (slot == SL_WRITE) && st_pend;
      if (slot == SL_SRC3)       st_pend <= mem_grant && !mq_load;
      else if (slot == SL_WRITE) st_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (slot == SL_WRITE && st_pend) st_data <= mem_rdata;
  end
endmodule

// File: rtl/vrf_checker.sv
module vrf_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] slot,
  input logic       iss_valid,
  input logic       iss_ready,
  input logic       op_valid,
  input logic       st_valid,
  input logic       res_valid,
  input logic       stg_full,
  input logic       mem_we,
  input logic       act_valid,
  input logic       act_use3
);
  // R2: slot sequence
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    (slot != 2'd3) |=> (slot == $past(slot) + 2'd1));
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (slot == 2'd3) |=> (slot == 2'd0));
  assert_issue_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |-> (slot == 2'd3));
  // R4: operands valid for a single slot-0 cycle
  assert_op_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (slot == 2'd0));
  assert_op_once_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);
  // R6 / R9: writes only in the write slot or a free third slot
  assert_write_slot_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (slot == 2'd3 || (slot == 2'd2 && !(act_valid && act_use3))));
  // R8: no result may arrive into a full staging register outside slot 3
  assert_no_lost_result_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && stg_full) |-> (slot == 2'd3));
  // R10: store data appears in slot 0
  assert_store_slot_R10: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (slot == 2'd0));
endmodule

bind slotted_vrf vrf_checker i_vrf_checker (
  .clk      (clk),
  .rst      (rst),
  .slot     (slot),
  .iss_valid(iss_valid),
  .iss_ready(iss_ready),
  .op_valid (op_valid),
  .st_valid (st_valid),
  .res_valid(res_valid),
  .stg_full (stg_full),
  .mem_we   (mem_we),
  .act_valid(act_valid),
  .act_use3 (act_use3)
);

// File: tb/test_slotted_vrf.sv
`timescale 1ns/1ps
module test_slotted_vrf;
  localparam int RW = 256;
  localparam int NG = 32;
  localparam int QD = 2;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 0, iss_use3 = 0;
  logic [4:0]    iss_src1_grp = 0, iss_src2_grp = 0, iss_src3_grp = 0;
  logic          res_valid = 0;
  logic [4:0]    res_grp = 0;
  logic [RW-1:0] res_data = 0;
  logic          mreq_valid = 0, mreq_load = 0;
  logic [4:0]    mreq_grp = 0;
  logic [RW-1:0] mreq_data = 0;
  logic          iss_ready, mreq_ready, op_valid, st_valid;
  logic [RW-1:0] op_a, op_b, op_c, st_data;

  always #2 clk = ~clk;

  slotted_vrf i_slotted_vrf (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src1_grp(iss_src1_grp), .iss_src2_grp(iss_src2_grp),
    .iss_src3_grp(iss_src3_grp), .iss_use3(iss_use3),
    .res_valid(res_valid), .res_grp(res_grp), .res_data(res_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_load(mreq_load),
    .mreq_grp(mreq_grp), .mreq_data(mreq_data),
    .op_valid(op_valid), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .st_valid(st_valid), .st_data(st_data)
  );

  int nvec = 0, nerr = 0, cyc = 0;
  bit chk_en = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [RW-1:0] act, input logic [RW-1:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] rand_row();
    logic [RW-1:0] r;
    for (int i = 0; i < RW/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // ---------------- reference model of the slot schedule ----------------
  logic [RW-1:0] m_mem [NG];
  int            m_slot = 0, m_qcnt = 0;
  bit            m_act = 0, m_u3 = 0, m_stg_full = 0, m_stp = 0;
  logic [4:0]    m_g1, m_g2, m_g3, m_sg;
  logic [RW-1:0] m_sd, ma, mb, mc, pst;
  bit            exp_opv = 0, exp_stv = 0;
  logic [RW-1:0] exp_a, exp_b, exp_c, exp_std;
  bit            q_ld [QD];
  logic [4:0]    q_g [QD];
  logic [RW-1:0] q_d [QD];
  bit            t_rdy, t_acc, t_push, t_grant;

  always @(posedge clk) begin
    if (rst) begin
      m_slot = 0; m_act = 0; m_u3 = 0; m_stg_full = 0; m_qcnt = 0;
      m_stp = 0; exp_opv = 0; exp_stv = 0;
    end else begin
      t_rdy   = (m_slot == 3) && !(m_stg_full && res_valid);
      t_acc   = iss_valid && t_rdy;
      t_push  = mreq_valid && (m_qcnt < QD);
      t_grant = (m_slot == 2) && !(m_act && m_u3) && (m_qcnt > 0);
      case (m_slot)
        0: begin ma = m_mem[m_g1]; exp_opv = 0; exp_stv = 0; end
        1: mb = m_mem[m_g2];
        2: begin
          mc = (m_act && m_u3) ? m_mem[m_g3] : '0;
          if (t_grant) begin
            if (q_ld[0]) m_mem[q_g[0]] = q_d[0];
            else begin pst = m_mem[q_g[0]]; m_stp = 1; end
          end
        end
        default: begin
          exp_opv = m_act; exp_a = ma; exp_b = mb; exp_c = mc;
          exp_stv = m_stp; exp_std = pst; m_stp = 0;
          if (m_stg_full) begin
            m_mem[m_sg] = m_sd;
            m_stg_full = res_valid;
            m_sg = res_grp; m_sd = res_data;
          end else if (res_valid) begin
            m_mem[res_grp] = res_data;
          end
          m_act = t_acc;
          m_u3  = t_acc && iss_use3;
          if (t_acc) begin m_g1 = iss_src1_grp; m_g2 = iss_src2_grp; m_g3 = iss_src3_grp; end
        end
      endcase
      if (m_slot != 3 && res_valid) begin
        m_stg_full = 1; m_sg = res_grp; m_sd = res_data;
      end
      if (t_grant) begin
        q_ld[0] = q_ld[1]; q_g[0] = q_g[1]; q_d[0] = q_d[1];
        m_qcnt--;
      end
      if (t_push) begin
        q_ld[m_qcnt] = mreq_load; q_g[m_qcnt] = mreq_grp; q_d[m_qcnt] = mreq_data;
        m_qcnt++;
      end
      m_slot = (m_slot + 1) % 4;
    end
  end

  // continuous comparison against the model
  always @(negedge clk) begin
    if (!rst && chk_en) begin
      bit rdy;
      rdy = (m_slot == 3) && !(m_stg_full && res_valid);
      chk(iss_ready === rdy, "R2", RW'(iss_ready), RW'(rdy));
      chk(mreq_ready === (m_qcnt < QD), "R12", RW'(mreq_ready), RW'(m_qcnt < QD));
      chk(op_valid === exp_opv, "R4", RW'(op_valid), RW'(exp_opv));
      if (exp_opv) begin
        chk(op_a === exp_a, "R4", op_a, exp_a);
        chk(op_b === exp_b, "R4", op_b, exp_b);
        chk(op_c === exp_c, "R5", op_c, exp_c);
      end
      chk(st_valid === exp_stv, "R10", RW'(st_valid), RW'(exp_stv));
      if (exp_stv) chk(st_data === exp_std, "R10", st_data, exp_std);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      nerr++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(posedge clk); #1; endtask

  task automatic idle();
    iss_valid = 0; res_valid = 0; mreq_valid = 0;
  endtask

  task automatic wait_slot(input int s);
    while (m_slot != s) tick();
  endtask

  task automatic issue(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] c, input bit u3);
    iss_valid = 1; iss_src1_grp = a; iss_src2_grp = b; iss_src3_grp = c; iss_use3 = u3;
  endtask

  initial begin
    logic [RW-1:0] d1, d2, lane_pat;
    int seed_sink;
    bit took;
    seed_sink = $urandom(32'd20240611);

    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(op_valid === 1'b0, "R1", RW'(op_valid), '0);
    chk(st_valid === 1'b0, "R1", RW'(st_valid), '0);
    chk(iss_ready === 1'b0, "R1", RW'(iss_ready), '0);
    chk(mreq_ready === 1'b1, "R1", RW'(mreq_ready), RW'(1));
    chk_en = 1;
    tick();

    // fill every group through loads (R11)
    for (int g = 0; g < NG; g++) begin
      mreq_valid = 1; mreq_load = 1; mreq_grp = 5'(g); mreq_data = rand_row();
      do begin took = (m_qcnt < QD); tick(); end while (!took);
    end
    idle();
    repeat (16) tick();

    // R3 / R5 / R7: write in slot 3, read in the next slot 0, lanes distinct
    for (int i = 0; i < 4; i++) lane_pat[i*64 +: 64] = {32'(i), 32'hA5A5_0000 + 32'(i)};
    wait_slot(3);
    res_valid = 1; res_grp = 5'd9; res_data = lane_pat;
    issue(5'd9, 5'd3, 5'd4, 1'b0);
    tick();
    idle();
    repeat (4) tick();
    #1;
    chk(op_valid === 1'b1, "R7", RW'(op_valid), RW'(1));
    chk(op_a === lane_pat, "R7", op_a, lane_pat);
    chk(op_a[127:64] === {32'd1, 32'hA5A5_0001}, "R3", RW'(op_a[127:64]),
        RW'({32'd1, 32'hA5A5_0001}));
    chk(op_c === '0, "R5", op_c, '0);
    tick();

    // R6 / R8: staged result, then collision in slot 3
    repeat (8) tick();
    d1 = rand_row(); d2 = rand_row();
    wait_slot(0);
    res_valid = 1; res_grp = 5'd20; res_data = d1;
    tick();
    res_valid = 0;
    wait_slot(3);
    res_valid = 1; res_grp = 5'd21; res_data = d2;
    issue(5'd20, 5'd21, 5'd0, 1'b0);
    #1;
    chk(iss_ready === 1'b0, "R8", RW'(iss_ready), '0);
    tick();
    idle();
    wait_slot(3);
    issue(5'd20, 5'd21, 5'd0, 1'b0);
    tick();
    idle();
    repeat (4) tick();
    #1;
    chk(op_a === d1, "R6", op_a, d1);
    chk(op_b === d2, "R6", op_b, d2);
    tick();

    // R9 / R12 / R11: loads wait while third slots are taken
    repeat (8) tick();
    d1 = rand_row(); d2 = rand_row();
    wait_slot(3);
    issue(5'd1, 5'd2, 5'd3, 1'b1);
    tick();
    iss_valid = 0;
    mreq_valid = 1; mreq_load = 1; mreq_grp = 5'd12; mreq_data = d1;
    tick();
    mreq_grp = 5'd13; mreq_data = d2;
    tick();
    mreq_grp = 5'd14; mreq_data = rand_row();
    #1;
    chk(mreq_ready === 1'b0, "R12", RW'(mreq_ready), '0);
    tick();
    mreq_valid = 0;
    issue(5'd5, 5'd6, 5'd7, 1'b1);
    #1;
    chk(mreq_ready === 1'b0, "R9", RW'(mreq_ready), '0);
    tick();
    idle();
    repeat (16) tick();
    wait_slot(3);
    issue(5'd12, 5'd13, 5'd0, 1'b0);
    tick();
    idle();
    repeat (4) tick();
    #1;
    chk(op_a === d1, "R11", op_a, d1);
    chk(op_b === d2, "R11", op_b, d2);
    tick();

    // R10: store response in the slot 0 after its slot 2
    repeat (8) tick();
    wait_slot(0);
    mreq_valid = 1; mreq_load = 0; mreq_grp = 5'd12;
    tick();
    idle();
    repeat (3) tick();
    #1;
    chk(st_valid === 1'b1, "R10", RW'(st_valid), RW'(1));
    chk(st_data === d1, "R10", st_data, d1);
    tick();

    // random rounds checked by the model
    for (int n = 0; n < 4000; n++) begin
      iss_valid    = ($urandom % 3) == 0;
      iss_src1_grp = 5'($urandom); iss_src2_grp = 5'($urandom);
      iss_src3_grp = 5'($urandom); iss_use3 = $urandom % 2;
      res_valid    = (($urandom % 4) == 0) && (!m_stg_full || m_slot == 3);
      res_grp      = 5'($urandom); res_data = rand_row();
      mreq_valid   = ($urandom % 3) == 0;
      mreq_load    = $urandom % 2; mreq_grp = 5'($urandom); mreq_data = rand_row();
      tick();
    end
    idle();
    repeat (20) tick();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule